// File: doc/BRIEF.md
# Floating-Gate Array Programming Sequencer

This block runs the iterative programming loop for an array of floating-gate cells. After `start` it reads every cell through a request/acknowledge measurement port. If any cell is still below its target, it raises the programming supply through a fixed number of equal DAC steps, holding each step for a settling time. It then visits each unfinished cell in address order. For each such cell it sets the drain DAC to a level looked up from a preloaded table, and enables only that cell's row and column for a programmable number of clock cycles. Finally it lowers the supply through the same steps, re-measures the whole array and repeats.

The drain level is the quiescent drain code plus a signed offset read from a table. The table is addressed by the upper bits of the latest reading and of the target. A cell whose reading reaches its target is finished for the rest of the run. The run ends with `done` when all cells are finished, or with `timeout` when the pulse-phase limit is used up.

Top module: `fgprog_seq`

## Requirements
- R1: After reset `busy`, `done`, `timeout`, `meas_req`, `inj`, `dac_upd` are 0 and `row_en`/`col_en` are all zero.
- R2: Each programming cycle reads all NCELLS cells in ascending address order. `meas_req` stays high with a stable `cell_addr` until `meas_ack`, and `meas_data` is taken at the acknowledged edge.
- R3: Ramp-up issues RAMP_STEPS updates on supply channel (`dac_ch`=0) with codes SUP_LO+k*SUP_STEP for k=1..RAMP_STEPS in order, consecutive updates exactly SETTLE cycles apart.
- R4: Ramp-down issues RAMP_STEPS supply updates with k=RAMP_STEPS-1 down to 0, consecutive updates exactly SETTLE cycles apart.
- R5: Before each pulse one drain update (`dac_ch`=1) carries QDRAIN plus table entry [{reading[CW-1:CW-QB], target[CW-1:CW-QB]}] modulo 2^DACW. The latest reading is in the upper half of the index.
- R6: `inj` rises exactly SETTLE cycles after the drain update and stays high max(`pulse_w`,1) cycles. While high, `row_en` is one-hot at `cell_addr`/NCOLS and `col_en` one-hot at `cell_addr`%NCOLS; both are zero otherwise.
- R7: A cell whose reading is greater than or equal to its target is finished and receives no pulse for the rest of the run.
- R8: Each pulse phase gives exactly one pulse to every unfinished cell, in ascending address order.
- R9: When all cells are finished after a measurement pass, `done` goes high, `busy` low, and no ramp follows.
- R10: When MAX_CYC pulse phases have run and a following measurement still finds unfinished cells, `timeout` goes high and `done` stays low.
- R11: `start` while `busy` is ignored and does not change the pulse sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a programming run (idle only) |
| pulse_w | input | PWW | Pulse width in cycles (0 treated as 1) |
| tgt_we | input | 1 | Target table write strobe |
| tgt_waddr | input | IW | Target table write cell index |
| tgt_wdata | input | CW | Target reading code |
| lut_we | input | 1 | Offset table write strobe |
| lut_waddr | input | 2*QB | Offset table write index |
| lut_wdata | input | DACW | Signed drain offset |
| meas_req | output | 1 | Measurement request |
| meas_ack | input | 1 | Measurement response valid |
| meas_data | input | CW | Measured reading code |
| cell_addr | output | IW | Cell under measurement or pulse |
| dac_code | output | DACW | DAC code |
| dac_ch | output | 1 | DAC channel: 0 supply, 1 drain |
| dac_upd | output | 1 | One-cycle DAC update strobe |
| inj | output | 1 | Injection pulse active |
| row_en | output | NCELLS/NCOLS | Row enables, one-hot during pulse |
| col_en | output | NCOLS | Column enables, one-hot during pulse |
| busy | output | 1 | Run in progress |
| done | output | 1 | All cells reached target |
| timeout | output | 1 | Cycle limit reached first |

## Verification
Several boundary cases are run. In one, every cell starts at or above target, so the run must stop after one pass with no ramp; a sequencer that ramps anyway shows extra supply updates. In another, a cell sits exactly on its target, and treating that cell as unfinished shows up as a stray pulse. A slow cell forces the phase limit, which catches an off-by-one in the cycle counter as a wrong pulse count or a missing `timeout`. A zero pulse width must still give a one-cycle pulse, where a plain down-counter would wrap. Random runs compare every drain code against the table with the readings the bench supplied, so a swapped index half or a stale reading gives a wrong code.

// File: rtl/fgprog_seq.sv
module fgprog_seq #(
  parameter int NCELLS     = 4,
  parameter int NCOLS      = 2,
  parameter int CW         = 8,
  parameter int QB         = 3,
  parameter int DACW       = 12,
  parameter int RAMP_STEPS = 10,
  parameter int SETTLE     = 5,
  parameter int MAX_CYC    = 30,
  parameter int PWW        = 16,
  parameter int SUP_LO     = 1024,
  parameter int SUP_STEP   = 100,
  parameter int QDRAIN     = 2048,
  localparam int IW    = (NCELLS > 1) ? $clog2(NCELLS) : 1,
  localparam int NROWS = NCELLS / NCOLS,
  localparam int LAW   = 2 * QB
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [PWW-1:0]   pulse_w,
  input  logic             tgt_we,
  input  logic [IW-1:0]    tgt_waddr,
  input  logic [CW-1:0]    tgt_wdata,
  input  logic             lut_we,
  input  logic [LAW-1:0]   lut_waddr,
  input  logic [DACW-1:0]  lut_wdata,
  output logic             meas_req,
  input  logic             meas_ack,
  input  logic [CW-1:0]    meas_data,
  output logic [IW-1:0]    cell_addr,
  output logic [DACW-1:0]  dac_code,
  output logic             dac_ch,
  output logic             dac_upd,
  output logic             inj,
  output logic [NROWS-1:0] row_en,
  output logic [NCOLS-1:0] col_en,
  output logic             busy,
  output logic             done,
  output logic             timeout
);
  localparam int SW   = $clog2(RAMP_STEPS + 1);
  localparam int CCW  = $clog2(MAX_CYC + 1);
  localparam int LUTD = 1 << LAW;
  localparam logic [IW-1:0] LAST = IW'(NCELLS - 1);

  typedef enum logic [2:0] {S_IDLE, S_MEAS, S_EVAL, S_RUP, S_PSEL, S_DSET, S_PULSE, S_RDN} st_t;

  st_t              state;
  logic [IW-1:0]    idx;
  logic [SW-1:0]    step;
  logic [PWW-1:0]   tmr;
  logic [CCW-1:0]   cyc;
  logic [NCELLS-1:0] fin;
  logic [CW-1:0]    cur_r [NCELLS];
  logic [CW-1:0]    tgt_r [NCELLS];
  logic [DACW-1:0]  lut   [LUTD];
  logic [LAW-1:0]   lut_a;
  logic [DACW-1:0]  drain_code;

  function automatic logic [DACW-1:0] sup(input int k);
    return DACW'(SUP_LO + k * SUP_STEP);
  endfunction

  assign lut_a      = {cur_r[idx][CW-1 -: QB], tgt_r[idx][CW-1 -: QB]};
  assign drain_code = DACW'(QDRAIN) + lut[lut_a];
  assign cell_addr  = idx;
  assign meas_req   = (state == S_MEAS);
  assign inj        = (state == S_PULSE);
  assign busy       = (state != S_IDLE);
  assign row_en     = inj ? (NROWS'(1) << (idx / IW'(NCOLS))) : '0;
  assign col_en     = inj ? (NCOLS'(1) << (idx % IW'(NCOLS))) : '0;

  always_ff @(posedge clk) begin
    if (tgt_we) tgt_r[tgt_waddr] <= tgt_wdata;
    if (lut_we) lut[lut_waddr] <= lut_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      idx      <= '0;
      step     <= '0;
      tmr      <= '0;
      cyc      <= '0;
      fin      <= '0;
      done     <= 1'b0;
      timeout  <= 1'b0;
      dac_code <= sup(0);
      dac_ch   <= 1'b0;
      dac_upd  <= 1'b0;
      for (int i = 0; i < NCELLS; i++) cur_r[i] <= '0;
    end else begin
      dac_upd <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          fin <= '0; cyc <= '0; idx <= '0; done <= 1'b0; timeout <= 1'b0;
          state <= S_MEAS;
        end
        S_MEAS: if (meas_ack) begin
          cur_r[idx] <= meas_data;
          if (meas_data >= tgt_r[idx]) fin[idx] <= 1'b1;
          if (idx == LAST) state <= S_EVAL;
          else idx <= idx + 1'b1;
        end
        S_EVAL: begin
          idx <= '0;
          if (&fin) begin
            done <= 1'b1; state <= S_IDLE;
          end else if (cyc == CCW'(MAX_CYC)) begin
            timeout <= 1'b1; state <= S_IDLE;
          end else begin
            step <= '0; tmr <= '0; state <= S_RUP;
          end
        end
        S_RUP: begin
          if (tmr != '0) tmr <= tmr - 1'b1;
          else if (step == SW'(RAMP_STEPS)) state <= S_PSEL;
          else begin
            step <= step + 1'b1;
            dac_ch <= 1'b0; dac_code <= sup(int'(step) + 1); dac_upd <= 1'b1;
            tmr <= PWW'(SETTLE - 1);
          end
        end
        S_PSEL: begin
          if (!fin[idx]) begin
            dac_ch <= 1'b1; dac_code <= drain_code; dac_upd <= 1'b1;
            tmr <= PWW'(SETTLE - 1); state <= S_DSET;
          end else if (idx == LAST) begin
            step <= SW'(RAMP_STEPS); tmr <= '0; state <= S_RDN;
          end else idx <= idx + 1'b1;
        end
        S_DSET: begin
          if (tmr != '0) tmr <= tmr - 1'b1;
          else begin
            tmr <= (pulse_w == '0) ? '0 : pulse_w - 1'b1;
            state <= S_PULSE;
          end
        end
        S_PULSE: begin
          if (tmr != '0) tmr <= tmr - 1'b1;
          else if (idx == LAST) begin
            step <= SW'(RAMP_STEPS); tmr <= '0; state <= S_RDN;
          end else begin
            idx <= idx + 1'b1; state <= S_PSEL;
          end
        end
        S_RDN: begin
          if (tmr != '0) tmr <= tmr - 1'b1;
          else if (step == '0) begin
            cyc <= cyc + 1'b1; idx <= '0; state <= S_MEAS;
          end else begin
            step <= step - 1'b1;
            dac_ch <= 1'b0; dac_code <= sup(int'(step) - 1); dac_upd <= 1'b1;
            tmr <= PWW'(SETTLE - 1);
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  a_r2_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    meas_req && !meas_ack |=> meas_req && $stable(cell_addr));
  a_r7_no_pulse_finished: assert property (@(posedge clk) disable iff (!rst_n)
    inj |-> !fin[cell_addr]);
  a_r6_drain_channel: assert property (@(posedge clk) disable iff (!rst_n)
    inj |-> dac_ch);
  a_r3_upd_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    dac_upd |=> !dac_upd);
  a_r10_cycle_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cyc <= CCW'(MAX_CYC));
  a_r9_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && timeout));
  a_r9_idle_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> !busy);
endmodule

// File: tb/fgprog_seq_tb_top.sv
module fgprog_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N = 4, NC = 2, CW = 8, QB = 3, DACW = 12;
  localparam int RS = 10, ST = 5, MAXC = 30, PWW = 16;
  localparam int LO = 1024, STP = 100, QD = 2048;
  localparam int IW = 2, NR = N / NC;

  logic clk = 0, rst_n = 0, start = 0;
  logic [PWW-1:0] pulse_w = '0;
  logic tgt_we = 0, lut_we = 0;
  logic [IW-1:0] tgt_waddr = '0;
  logic [CW-1:0] tgt_wdata = '0;
  logic [2*QB-1:0] lut_waddr = '0;
  logic [DACW-1:0] lut_wdata = '0;
  logic meas_req, meas_ack = 0;
  logic [CW-1:0] meas_data = '0;
  logic [IW-1:0] cell_addr;
  logic [DACW-1:0] dac_code;
  logic dac_ch, dac_upd, inj, busy, done, timeout;
  logic [NR-1:0] row_en;
  logic [NC-1:0] col_en;

  always #(CLK_PERIOD/2) clk = ~clk;

  fgprog_seq #(.NCELLS(N), .NCOLS(NC), .CW(CW), .QB(QB), .DACW(DACW), .RAMP_STEPS(RS),
    .SETTLE(ST), .MAX_CYC(MAXC), .PWW(PWW), .SUP_LO(LO), .SUP_STEP(STP), .QDRAIN(QD)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .pulse_w(pulse_w),
    .tgt_we(tgt_we), .tgt_waddr(tgt_waddr), .tgt_wdata(tgt_wdata),
    .lut_we(lut_we), .lut_waddr(lut_waddr), .lut_wdata(lut_wdata),
    .meas_req(meas_req), .meas_ack(meas_ack), .meas_data(meas_data), .cell_addr(cell_addr),
    .dac_code(dac_code), .dac_ch(dac_ch), .dac_upd(dac_upd), .inj(inj),
    .row_en(row_en), .col_en(col_en), .busy(busy), .done(done), .timeout(timeout));

  int vec = 0, bad = 0, total_cyc = 0;
  int model [N], tgt_m [N], dlt [N], last_meas [N], pulses [N];
  int lut_m [64];
  int ramp_i = 0, since_sup = 0, since_drn = 0, pw_cnt = 0, pw_exp = 1, last_pa = -1;
  int pulse_a = 0, meas_cnt = 0, sup_cnt = 0, wait_n = 0;
  bit prev_inj = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vec++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_drain(input int a);
    int ix;
    ix = ((last_meas[a] >> (CW-QB)) << QB) | (tgt_m[a] >> (CW-QB));
    return (QD + lut_m[ix]) & ((1 << DACW) - 1);
  endfunction

  always @(negedge clk) begin
    total_cyc++;
    if (rst_n) begin
      since_sup++; since_drn++;
      if (dac_upd && !dac_ch) begin
        int k;
        k = (ramp_i < RS) ? ramp_i + 1 : 2*RS - 1 - ramp_i;
        if (ramp_i < RS) chk(int'(dac_code) == LO + k*STP, "R3 supply code", int'(dac_code), LO + k*STP);
        else             chk(int'(dac_code) == LO + k*STP, "R4 supply code", int'(dac_code), LO + k*STP);
        if (ramp_i % RS != 0) begin
          if (ramp_i < RS) chk(since_sup == ST, "R3 step spacing", since_sup, ST);
          else             chk(since_sup == ST, "R4 step spacing", since_sup, ST);
        end
        ramp_i = (ramp_i + 1) % (2*RS);
        since_sup = 0; last_pa = -1; sup_cnt++;
      end
      if (dac_upd && dac_ch) begin
        chk(int'(dac_code) == exp_drain(int'(cell_addr)), "R5 drain code", int'(dac_code), exp_drain(int'(cell_addr)));
        since_drn = 0;
      end
      if (inj && !prev_inj) begin
        pulse_a = int'(cell_addr);
        chk(since_drn == ST, "R6 pulse delay", since_drn, ST);
        chk(row_en == NR'(1 << (pulse_a / NC)) && col_en == NC'(1 << (pulse_a % NC)),
            "R6 row/col select", {row_en, col_en}, ((1 << (pulse_a/NC)) << NC) | (1 << (pulse_a%NC)));
        chk(pulse_a > last_pa, "R8 ascending order", pulse_a, last_pa + 1);
        chk(last_meas[pulse_a] < tgt_m[pulse_a], "R7 finished cell pulsed", last_meas[pulse_a], tgt_m[pulse_a]);
        last_pa = pulse_a; pulses[pulse_a]++; pw_cnt = 0;
      end
      if (inj) pw_cnt++;
      if (!inj && prev_inj) begin
        chk(pw_cnt == pw_exp, "R6 pulse width", pw_cnt, pw_exp);
        chk(row_en == '0 && col_en == '0, "R6 deselect", {row_en, col_en}, 0);
        model[pulse_a] = (model[pulse_a] + dlt[pulse_a] > 255) ? 255 : model[pulse_a] + dlt[pulse_a];
      end
      prev_inj = inj;
      if (meas_ack) begin
        meas_ack <= 1'b0;
        wait_n = $urandom_range(0, 2);
      end else if (meas_req) begin
        if (wait_n == 0) begin
          meas_ack <= 1'b1;
          meas_data <= CW'(model[cell_addr]);
          last_meas[cell_addr] = model[cell_addr];
          meas_cnt++;
        end else wait_n--;
      end
    end
  end

  task automatic run_case(input int i0 [N], input int t0 [N], input int d0 [N], input int pw, input bit poke);
    int need [N];
    int kmax, keff, cnt;
    bit to;
    for (int i = 0; i < N; i++) begin
      @(negedge clk);
      tgt_we = 1; tgt_waddr = IW'(i); tgt_wdata = CW'(t0[i]);
      model[i] = i0[i]; tgt_m[i] = t0[i]; dlt[i] = d0[i]; pulses[i] = 0; last_meas[i] = 0;
    end
    @(negedge clk);
    tgt_we = 0; pulse_w = PWW'(pw);
    pw_exp = (pw == 0) ? 1 : pw;
    ramp_i = 0; meas_cnt = 0; sup_cnt = 0;
    start = 1;
    @(negedge clk);
    start = 0;
    cnt = 0;
    while (!(done || timeout) && cnt < 30000) begin
      @(negedge clk);
      cnt++;
      if (poke && cnt == 200) start = 1;
      else start = 0;
    end
    start = 0;
    chk(cnt < 30000, "R9 run hung", cnt, 30000);
    kmax = 0;
    for (int i = 0; i < N; i++) begin
      need[i] = (i0[i] >= t0[i]) ? 0 : (t0[i] - i0[i] + d0[i] - 1) / d0[i];
      if (need[i] > kmax) kmax = need[i];
    end
    to = (kmax > MAXC);
    keff = to ? MAXC : kmax;
    chk(done == !to, "R9 done flag", done, !to);
    chk(timeout == to, "R10 timeout flag", timeout, to);
    chk(!busy && !meas_req, "R9 idle after end", {busy, meas_req}, 0);
    chk(meas_cnt == N*(keff+1), "R2 measurement count", meas_cnt, N*(keff+1));
    chk(sup_cnt == 2*RS*keff, "R9 supply updates", sup_cnt, 2*RS*keff);
    for (int i = 0; i < N; i++) begin
      int e;
      e = (need[i] < keff) ? need[i] : keff;
      if (poke) chk(pulses[i] == e, "R11 pulses after busy start", pulses[i], e);
      else      chk(pulses[i] == e, "R8 pulses per cell", pulses[i], e);
    end
    repeat (3) @(negedge clk);
  endtask

  always @(negedge clk) if (total_cyc > 190000) begin
    bad++; vec++;
    $display("FAIL watchdog: actual %0d expected below %0d", total_cyc, 190000);
    $display("  == %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    int i0 [N], t0 [N], d0 [N];
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(!busy && !done && !timeout && !meas_req && !inj && !dac_upd && row_en == '0 && col_en == '0,
        "R1 reset state", {busy, done, timeout, meas_req, inj, dac_upd}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && !meas_req && !inj, "R1 idle after reset", {busy, meas_req, inj}, 0);
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      lut_m[i] = $urandom_range(0, 100) - 50;
      lut_we = 1; lut_waddr = 6'(i); lut_wdata = DACW'(lut_m[i]);
    end
    @(negedge clk);
    lut_we = 0;
    // R9: all cells already at or above target
    i0 = '{200, 100, 255, 60}; t0 = '{150, 100, 255, 10}; d0 = '{5, 5, 5, 5};
    run_case(i0, t0, d0, 3, 0);
    // R7 boundary: cell 1 exactly on target
    i0 = '{10, 90, 30, 0}; t0 = '{100, 90, 200, 40}; d0 = '{20, 7, 30, 9};
    run_case(i0, t0, d0, 4, 0);
    // R10: slow cell exceeds phase limit
    i0 = '{0, 50, 100, 0}; t0 = '{40, 60, 120, 10}; d0 = '{1, 10, 20, 10};
    run_case(i0, t0, d0, 2, 0);
    // R6: zero width pulse
    i0 = '{0, 0, 0, 0}; t0 = '{30, 60, 90, 120}; d0 = '{30, 30, 30, 30};
    run_case(i0, t0, d0, 0, 0);
    // R11: start asserted mid-run
    i0 = '{5, 15, 25, 35}; t0 = '{100, 110, 120, 130}; d0 = '{25, 25, 25, 25};
    run_case(i0, t0, d0, 5, 1);
    for (int r = 0; r < 6; r++) begin
      for (int i = 0; i < N; i++) begin
        i0[i] = $urandom_range(0, 150);
        t0[i] = i0[i] + $urandom_range(0, 100);
        if (t0[i] > 255) t0[i] = 255;
        d0[i] = $urandom_range(5, 40);
      end
      run_case(i0, t0, d0, $urandom_range(1, 12), 0);
    end
    $display("  == %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule